// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block sits between a simple in-order core and a single-port word memory. The core hands it stores only after they retire. The buffer holds them in an 8-entry queue and writes them to memory one at a time, oldest first. A load may overtake buffered stores. When its word address matches one or more buffered stores, the load is answered from the youngest of them. When nothing matches, the load reads memory.

A separate request port lets the core order its traffic. A store fence holds back later stores, a load fence holds back later loads, and a full fence holds back both. A locked or serializing operation also holds back both, and it waits until the queue has drained before the core may run it. A `sb_empty` output shows when the queue holds no stores.

Two state machines control the block:
- The load machine has the states LD_IDLE, LD_ISSUE, LD_WAIT and LD_REPLY. Its transitions are:
  - IDLE to REPLY on a forwarded load.
  - IDLE to ISSUE on a miss.
  - ISSUE to WAIT when the memory accepts the read.
  - WAIT to REPLY on read data.
  - REPLY to IDLE after one cycle.
- The ordering machine has the states FN_IDLE, FN_STORE, FN_LOAD, FN_FULL and FN_LOCK.
  - IDLE goes to the state picked by the request kind.
  - STORE returns to IDLE when the queue is empty.
  - LOAD returns to IDLE when the load machine is idle.
  - FULL and LOCK return to IDLE when both conditions hold.
  - Each return to IDLE raises `fn_done` for that cycle.

Top module: `store_buffer_fwd`

## Requirements
- R1: Buffered stores appear on the memory port as writes in exactly the order they were accepted. At most one store drains per cycle, on `mem_valid && mem_we && mem_ready`.
- R2: With 8 stores held, `st_stall` is high and an offered store is not taken. A store that was offered and then withdrawn is never written.
- R3: A load whose word address (`addr[31:2]`, low two bits ignored) matches a buffered store returns the data of the youngest matching store. `ld_resp_valid` and `ld_resp_fwd` are high in the cycle after the load is accepted.
- R4: A load that matches no buffered store reads memory. Its response comes the cycle after `mem_rvalid`, with `ld_resp_fwd` low. While that read waits for the port, `st_stall` is high.
- R5: Writes win the memory port. A read is presented (`mem_valid && !mem_we`) only while the queue is empty.
- R6: A store fence (`fn_kind` 2'b00) sets `st_stall` until the queue is empty. Loads are still accepted meanwhile. `fn_done` pulses when the queue is empty.
- R7: A load fence (`fn_kind` 2'b01) holds `ld_ready` low until the earlier load has been answered. `fn_done` pulses after that response.
- R8: A full fence (`fn_kind` 2'b10) holds back both loads and stores until the queue is empty and no load is in flight. It then pulses `fn_done`.
- R9: A lock request (`fn_kind` 2'b11) blocks loads and stores the same way. `fn_done`, which tells the core it may now run the locked operation, never rises while stores remain buffered.
- R10: `sb_empty` is high exactly when no store is buffered. It rises only after a write drains the last entry.
- R11: After reset, the following are all high: `sb_empty`, `ld_ready` and `fn_ready`. The following are all low: `st_stall`, `mem_valid` and `ld_resp_valid`.
- R12: A store and a load offered in the same cycle are taken store first. `ld_ready` is low in that cycle, and the load is then answered from the store if their addresses match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Retired store offered |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store data word |
| st_stall | output | 1 | Store not taken this cycle |
| ld_valid | input | 1 | Load request |
| ld_addr | input | 32 | Load byte address |
| ld_ready | output | 1 | Load taken when valid |
| ld_resp_valid | output | 1 | Load data valid |
| ld_resp_data | output | 32 | Load data |
| ld_resp_fwd | output | 1 | Response came from the buffer |
| fn_valid | input | 1 | Ordering request |
| fn_kind | input | 2 | 00 store fence, 01 load fence, 10 full fence, 11 lock |
| fn_ready | output | 1 | Ordering request taken when valid |
| fn_done | output | 1 | Ordering condition met, one cycle |
| sb_empty | output | 1 | No store buffered |
| mem_valid | output | 1 | Memory access presented |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory takes the access |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Read data |

## Verification
The bench targets the following corner cases:

- **Several stores to one word with the memory stalled.** A design that forwarded the oldest match, or compared byte addresses, would return stale data.
- **Fill to the limit and offer a ninth store.** A design that let the ninth store in would overwrite the oldest entry or leave a write in the log that should not be there.
- **A load and a store to the same word offered together.** A design that took the load first would read memory before the store and return the old value.
- **A load miss while a write is pending, and each fence kind with the memory stalled.** A design with the wrong priority would read ahead of a drain. A design that released a fence too early would raise `fn_done` while stores were still buffered.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic [1:0] {
        FK_STORE = 2'b00,
        FK_LOAD  = 2'b01,
        FK_FULL  = 2'b10,
        FK_LOCK  = 2'b11
    } fence_kind_e;

    typedef enum logic [2:0] {
        FN_IDLE,
        FN_STORE,
        FN_LOAD,
        FN_FULL,
        FN_LOCK
    } fence_state_e;

    typedef enum logic [1:0] {
        LD_IDLE,
        LD_ISSUE,
        LD_WAIT,
        LD_REPLY
    } load_state_e;

endpackage

// File: rtl/sb_queue.sv
// Circular store queue with parallel word-address lookup for forwarding.
module sb_queue #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enq,
    input  logic [AW-1:0] enq_addr,
    input  logic [DW-1:0] enq_data,
    input  logic          deq,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    input  logic [AW-3:0] lk_word,
    output logic          lk_hit,
    output logic [DW-1:0] lk_data,
    output logic          full,
    output logic          empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [AW-1:0]    addr_q [DEPTH];
    logic [DW-1:0]    data_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] match;
    logic [PW-1:0]    head_q, tail_q;
    logic [CW-1:0]    count_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    // payload storage, written only at the tail
    always_ff @(posedge clk) begin
        if (enq) begin
            addr_q[tail_q] <= enq_addr;
            data_q[tail_q] <= enq_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
            vld_q   <= '0;
        end else begin
            if (enq) begin
                tail_q         <= bump(tail_q);
                vld_q[tail_q]  <= 1'b1;
            end
            if (deq) begin
                head_q         <= bump(head_q);
                vld_q[head_q]  <= 1'b0;
            end
            count_q <= count_q + CW'(enq) - CW'(deq);
        end
    end

    // one comparator per slot, all in the same cycle
    for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
        assign match[s] = vld_q[s] && (addr_q[s][AW-1:2] == lk_word);
    end

    // walk from oldest to youngest; the last hit wins
    always_comb begin
        logic [PW-1:0] slot;
        lk_hit  = 1'b0;
        lk_data = '0;
        slot    = head_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[slot]) begin
                lk_hit  = 1'b1;
                lk_data = data_q[slot];
            end
            slot = bump(slot);
        end
    end

    assign head_addr = addr_q[head_q];
    assign head_data = data_q[head_q];
    assign full      = (count_q == CW'(DEPTH));
    assign empty     = (count_q == '0);

endmodule

// File: rtl/sb_load_fsm.sv
// Load sequencer: forwarded reply, or one memory read at a time.
module sb_load_fsm
    import sb_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_fire,
    input  logic [AW-1:0] ld_addr,
    input  logic          fwd_hit,
    input  logic [DW-1:0] fwd_data,
    input  logic          rd_grant,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    output logic          hold_st,
    output logic          idle,
    output logic          resp_valid,
    output logic [DW-1:0] resp_data,
    output logic          resp_fwd
);
    load_state_e   st_q, st_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          fwd_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LD_IDLE:  if (ld_fire)    st_d = fwd_hit ? LD_REPLY : LD_ISSUE;
            LD_ISSUE: if (rd_grant)   st_d = LD_WAIT;
            LD_WAIT:  if (mem_rvalid) st_d = LD_REPLY;
            LD_REPLY:                 st_d = LD_IDLE;
            default:                  st_d = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LD_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            fwd_q  <= 1'b0;
        end else if (st_q == LD_IDLE && ld_fire) begin
            addr_q <= ld_addr;
            data_q <= fwd_data;
            fwd_q  <= fwd_hit;
        end else if (st_q == LD_WAIT && mem_rvalid) begin
            data_q <= mem_rdata;
        end
    end

    always_comb begin
        rd_req     = 1'b0;
        hold_st    = 1'b0;
        idle       = 1'b0;
        resp_valid = 1'b0;
        unique case (st_q)
            LD_IDLE:  idle       = 1'b1;
            LD_ISSUE: begin
                rd_req  = 1'b1;
                hold_st = 1'b1;
            end
            LD_WAIT:  ;
            LD_REPLY: resp_valid = 1'b1;
            default:  ;
        endcase
    end

    assign rd_addr   = addr_q;
    assign resp_data = data_q;
    assign resp_fwd  = fwd_q;

endmodule

// File: rtl/sb_fence_fsm.sv
// Ordering controller for store, load and full fences and locked operations.
module sb_fence_fsm
    import sb_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fn_valid,
    input  fence_kind_e  fn_kind,
    input  logic         st_valid,
    input  logic         ld_valid,
    input  logic         q_empty,
    input  logic         load_idle,
    output logic         fn_ready,
    output logic         fn_done,
    output logic         blk_st,
    output logic         blk_ld,
    output fence_state_e state
);
    fence_state_e st_q, st_d;
    logic         drained;

    assign drained = q_empty && load_idle;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FN_IDLE: begin
                if (fn_valid && fn_ready) begin
                    unique case (fn_kind)
                        FK_STORE: st_d = FN_STORE;
                        FK_LOAD:  st_d = FN_LOAD;
                        FK_FULL:  st_d = FN_FULL;
                        FK_LOCK:  st_d = FN_LOCK;
                        default:  st_d = FN_IDLE;
                    endcase
                end
            end
            FN_STORE: if (q_empty)   st_d = FN_IDLE;
            FN_LOAD:  if (load_idle) st_d = FN_IDLE;
            FN_FULL:  if (drained)   st_d = FN_IDLE;
            FN_LOCK:  if (drained)   st_d = FN_IDLE;
            default:                 st_d = FN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FN_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        fn_ready = 1'b0;
        fn_done  = 1'b0;
        blk_st   = 1'b0;
        blk_ld   = 1'b0;
        unique case (st_q)
            FN_IDLE:  fn_ready = !st_valid && !ld_valid;
            FN_STORE: begin
                blk_st  = 1'b1;
                fn_done = q_empty;
            end
            FN_LOAD: begin
                blk_ld  = 1'b1;
                fn_done = load_idle;
            end
            FN_FULL, FN_LOCK: begin
                blk_st  = 1'b1;
                blk_ld  = 1'b1;
                fn_done = drained;
            end
            default: ;
        endcase
    end

    assign state = st_q;

endmodule

// File: rtl/sb_port_arb.sv
// Single memory port: buffered writes first, load reads only when no write waits.
module sb_port_arb #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          wr_req,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    input  logic          mem_ready,
    output logic          mem_valid,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          wr_grant,
    output logic          rd_grant
);
    always_comb begin
        mem_valid = wr_req || rd_req;
        mem_we    = wr_req;
        mem_addr  = wr_req ? wr_addr : rd_addr;
        mem_wdata = wr_data;
        wr_grant  = wr_req && mem_ready;
        rd_grant  = !wr_req && rd_req && mem_ready;
    end
endmodule

// File: rtl/store_buffer_fwd.sv
module store_buffer_fwd
    import sb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    output logic          st_stall,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_ready,
    output logic          ld_resp_valid,
    output logic [DW-1:0] ld_resp_data,
    output logic          ld_resp_fwd,
    input  logic          fn_valid,
    input  logic [1:0]    fn_kind,
    output logic          fn_ready,
    output logic          fn_done,
    output logic          sb_empty,
    output logic          mem_valid,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ready,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata
);
    logic          enq, deq, q_full, q_empty;
    logic [AW-1:0] head_addr, rd_addr;
    logic [DW-1:0] head_data, fwd_data;
    logic          fwd_hit, rd_req, rd_grant, hold_st, load_idle;
    logic          blk_st, blk_ld, ld_fire;
    fence_state_e  fn_state;

    assign st_stall = q_full || blk_st || hold_st;
    assign enq      = st_valid && !st_stall;
    assign ld_ready = load_idle && !blk_ld && !st_valid;
    assign ld_fire  = ld_valid && ld_ready;
    assign sb_empty = q_empty;

    sb_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .enq       (enq),
        .enq_addr  (st_addr),
        .enq_data  (st_data),
        .deq       (deq),
        .head_addr (head_addr),
        .head_data (head_data),
        .lk_word   (ld_addr[AW-1:2]),
        .lk_hit    (fwd_hit),
        .lk_data   (fwd_data),
        .full      (q_full),
        .empty     (q_empty)
    );

    sb_load_fsm #(.AW(AW), .DW(DW)) u_load (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_fire    (ld_fire),
        .ld_addr    (ld_addr),
        .fwd_hit    (fwd_hit),
        .fwd_data   (fwd_data),
        .rd_grant   (rd_grant),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .hold_st    (hold_st),
        .idle       (load_idle),
        .resp_valid (ld_resp_valid),
        .resp_data  (ld_resp_data),
        .resp_fwd   (ld_resp_fwd)
    );

    sb_fence_fsm u_fence (
        .clk       (clk),
        .rst_n     (rst_n),
        .fn_valid  (fn_valid),
        .fn_kind   (fence_kind_e'(fn_kind)),
        .st_valid  (st_valid),
        .ld_valid  (ld_valid),
        .q_empty   (q_empty),
        .load_idle (load_idle),
        .fn_ready  (fn_ready),
        .fn_done   (fn_done),
        .blk_st    (blk_st),
        .blk_ld    (blk_ld),
        .state     (fn_state)
    );

    sb_port_arb #(.AW(AW), .DW(DW)) u_arb (
        .wr_req    (!q_empty),
        .wr_addr   (head_addr),
        .wr_data   (head_data),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .mem_ready (mem_ready),
        .mem_valid (mem_valid),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .wr_grant  (deq),
        .rd_grant  (rd_grant)
    );

endmodule

// File: rtl/sb_checker.sv
module sb_checker
    import sb_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         st_stall,
    input logic         enq,
    input logic         q_full,
    input logic         q_empty,
    input logic         mem_valid,
    input logic         mem_we,
    input logic         mem_ready,
    input logic         ld_ready,
    input logic         ld_resp_valid,
    input logic         fn_done,
    input fence_state_e fn_state
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !enq); // R2
    AST_FWD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_resp_valid |=> !ld_resp_valid); // R3
    AST_READ_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_we) |-> q_empty); // R5
    AST_STORE_FENCE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_state == FN_STORE) |-> st_stall); // R6
    AST_LOAD_FENCE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_state == FN_LOAD) |-> !ld_ready); // R7
    AST_FULL_FENCE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_state == FN_FULL) |-> (st_stall && !ld_ready)); // R8
    AST_LOCK_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_done && fn_state == FN_LOCK) |-> q_empty); // R9
    AST_EMPTY_BY_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_empty) |-> $past(mem_valid && mem_we && mem_ready)); // R10
endmodule

bind store_buffer_fwd sb_checker u_sb_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .st_stall      (st_stall),
    .enq           (enq),
    .q_full        (q_full),
    .q_empty       (q_empty),
    .mem_valid     (mem_valid),
    .mem_we        (mem_we),
    .mem_ready     (mem_ready),
    .ld_ready      (ld_ready),
    .ld_resp_valid (ld_resp_valid),
    .fn_done       (fn_done),
    .fn_state      (fn_state)
);

// File: tb/store_buffer_fwd_bench.sv
module store_buffer_fwd_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0, ld_valid = 1'b0, fn_valid = 1'b0;
    logic [31:0] st_addr = '0, st_data = '0, ld_addr = '0;
    logic [1:0]  fn_kind = '0;
    logic        mem_ready = 1'b0;
    logic        st_stall, ld_ready, ld_resp_valid, ld_resp_fwd, fn_ready, fn_done, sb_empty;
    logic [31:0] ld_resp_data, mem_addr, mem_wdata;
    logic        mem_valid, mem_we;
    logic        rv;
    logic [31:0] rd;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    store_buffer_fwd u_store_buffer_fwd (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_stall(st_stall),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_ready(ld_ready),
        .ld_resp_valid(ld_resp_valid), .ld_resp_data(ld_resp_data), .ld_resp_fwd(ld_resp_fwd),
        .fn_valid(fn_valid), .fn_kind(fn_kind), .fn_ready(fn_ready), .fn_done(fn_done),
        .sb_empty(sb_empty),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rvalid(rv), .mem_rdata(rd)
    );

    // memory model: 16 words, read data one cycle after the read is taken
    logic [31:0] mem [16];
    logic [31:0] log_addr [32];
    logic [31:0] log_data [32];
    int          log_n;
    int          bad_rd;
    int          resp_cnt;
    logic [31:0] last_resp;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= 32'hA000_0000 + 32'(i);
            log_n    <= 0;
            bad_rd   <= 0;
            resp_cnt <= 0;
            rv       <= 1'b0;
            rd       <= '0;
        end else begin
            rv <= 1'b0;
            if (mem_valid && !mem_we && !sb_empty) bad_rd <= bad_rd + 1;
            if (ld_resp_valid) begin
                resp_cnt  <= resp_cnt + 1;
                last_resp <= ld_resp_data;
            end
            if (mem_valid && mem_ready) begin
                if (mem_we) begin
                    mem[mem_addr[5:2]] <= mem_wdata;
                    if (log_n < 32) begin
                        log_addr[log_n] <= mem_addr;
                        log_data[log_n] <= mem_wdata;
                    end
                    log_n <= log_n + 1;
                end else begin
                    rv <= 1'b1;
                    rd <= mem[mem_addr[5:2]];
                end
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_store(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); st_valid = 1'b1; st_addr = a; st_data = d;
        #1; while (st_stall) begin @(negedge clk); #1; end
        @(negedge clk); st_valid = 1'b0;
    endtask

    task automatic load_issue(input logic [31:0] a);
        @(negedge clk); ld_valid = 1'b1; ld_addr = a;
        #1; while (!ld_ready) begin @(negedge clk); #1; end
        @(negedge clk); ld_valid = 1'b0;
    endtask

    task automatic load_wait(output logic [31:0] d, output logic f);
        #1; while (!ld_resp_valid) begin @(negedge clk); #1; end
        d = ld_resp_data; f = ld_resp_fwd;
    endtask

    task automatic wait_empty();
        @(negedge clk); #1;
        while (!sb_empty) begin @(negedge clk); #1; end
    endtask

    task automatic fence_req(input logic [1:0] k);
        @(negedge clk); fn_valid = 1'b1; fn_kind = k;
        #1; while (!fn_ready) begin @(negedge clk); #1; end
        @(negedge clk); fn_valid = 1'b0; #1;
    endtask

    task automatic wait_done();
        while (!fn_done) begin @(negedge clk); #1; end
    endtask

    typedef struct packed {
        logic [1:0]  op;    // 0 store, 1 load, 2 release memory and drain
        logic [31:0] addr;
        logic [31:0] val;
        logic        fwd;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{2'd0, 32'h10, 32'h1111, 1'b0},
        '{2'd0, 32'h14, 32'h2222, 1'b0},
        '{2'd0, 32'h10, 32'h3333, 1'b0},
        '{2'd1, 32'h10, 32'h3333, 1'b1},
        '{2'd1, 32'h13, 32'h3333, 1'b1},
        '{2'd1, 32'h14, 32'h2222, 1'b1},
        '{2'd0, 32'h14, 32'h4444, 1'b0},
        '{2'd1, 32'h16, 32'h4444, 1'b1},
        '{2'd2, 32'h00, 32'h0000, 1'b0},
        '{2'd1, 32'h10, 32'h3333, 1'b0},
        '{2'd1, 32'h20, 32'hA000_0008, 1'b0},
        '{2'd1, 32'h3C, 32'hA000_000F, 1'b0}
    };

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        f;
        int          rc;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R11 reset state
        chk(sb_empty == 1'b1, "R11 empty", 32'(sb_empty), 32'd1);
        chk(st_stall == 1'b0, "R11 st_stall", 32'(st_stall), 32'd0);
        chk(ld_ready == 1'b1 && fn_ready == 1'b1, "R11 ready", {30'd0, ld_ready, fn_ready}, 32'd3);
        chk(mem_valid == 1'b0 && ld_resp_valid == 1'b0, "R11 idle", {30'd0, mem_valid, ld_resp_valid}, 32'd0);

        // vector table, memory stalled at first so stores stay buffered
        mem_ready = 1'b0;
        for (int i = 0; i < 12; i++) begin
            if (VEC[i].op == 2'd0) begin
                do_store(VEC[i].addr, VEC[i].val);
                #1; chk(sb_empty == 1'b0, "R10 not empty", 32'(sb_empty), 32'd0);
            end else if (VEC[i].op == 2'd1) begin
                load_issue(VEC[i].addr);
                load_wait(d, f);
                chk(d == VEC[i].val, VEC[i].fwd ? "R3 data" : "R4 data", d, VEC[i].val);
                chk(f == VEC[i].fwd, VEC[i].fwd ? "R3 fwd" : "R4 fwd", 32'(f), 32'(VEC[i].fwd));
            end else begin
                mem_ready = 1'b1;
                wait_empty();
            end
        end
        // R1 drain order
        chk(log_n == 4, "R1 write count", 32'(log_n), 32'd4);
        chk(log_addr[0] == 32'h10 && log_data[0] == 32'h1111, "R1 w0", log_data[0], 32'h1111);
        chk(log_addr[1] == 32'h14 && log_data[1] == 32'h2222, "R1 w1", log_data[1], 32'h2222);
        chk(log_addr[2] == 32'h10 && log_data[2] == 32'h3333, "R1 w2", log_data[2], 32'h3333);
        chk(log_addr[3] == 32'h14 && log_data[3] == 32'h4444, "R1 w3", log_data[3], 32'h4444);

        // R2 fill to eight, offer a ninth
        mem_ready = 1'b0;
        for (int i = 0; i < 8; i++) do_store(32'(i * 4), 32'hB0 + 32'(i));
        @(negedge clk); st_valid = 1'b1; st_addr = 32'h20; st_data = 32'hDEAD; #1;
        chk(st_stall == 1'b1, "R2 stall when full", 32'(st_stall), 32'd1);
        @(negedge clk); #1;
        chk(st_stall == 1'b1, "R2 stall held", 32'(st_stall), 32'd1);
        st_valid = 1'b0;
        mem_ready = 1'b1;
        wait_empty();
        chk(log_n == 12, "R2 ninth not written", 32'(log_n), 32'd12);
        for (int i = 0; i < 8; i++)
            chk(log_addr[4+i] == 32'(i * 4) && log_data[4+i] == 32'hB0 + 32'(i),
                "R1 fill order", log_data[4+i], 32'hB0 + 32'(i));
        load_issue(32'h20);
        load_wait(d, f);
        chk(d == 32'hA000_0008, "R2 word untouched", d, 32'hA000_0008);

        // R4 and R5: miss while a write is pending
        mem_ready = 1'b0;
        do_store(32'h24, 32'h5555);
        load_issue(32'h28);
        #1;
        chk(st_stall == 1'b1, "R4 stores held during miss", 32'(st_stall), 32'd1);
        chk(mem_valid == 1'b1 && mem_we == 1'b1, "R5 write first", {30'd0, mem_valid, mem_we}, 32'd3);
        mem_ready = 1'b1;
        load_wait(d, f);
        chk(d == 32'hA000_000A && f == 1'b0, "R4 miss data", d, 32'hA000_000A);
        wait_empty();

        // R12 same-cycle store and load
        mem_ready = 1'b0;
        @(negedge clk); st_valid = 1'b1; st_addr = 32'h30; st_data = 32'h7777;
        ld_valid = 1'b1; ld_addr = 32'h30; #1;
        chk(ld_ready == 1'b0, "R12 load waits", 32'(ld_ready), 32'd0);
        @(negedge clk); st_valid = 1'b0; #1;
        chk(ld_ready == 1'b1, "R12 load next", 32'(ld_ready), 32'd1);
        @(negedge clk); ld_valid = 1'b0;
        load_wait(d, f);
        chk(d == 32'h7777 && f == 1'b1, "R12 forwarded", d, 32'h7777);
        mem_ready = 1'b1;
        wait_empty();

        // R6 store fence
        mem_ready = 1'b0;
        do_store(32'h34, 32'h8888);
        fence_req(2'b00);
        chk(st_stall == 1'b1, "R6 stores blocked", 32'(st_stall), 32'd1);
        chk(ld_ready == 1'b1, "R6 loads allowed", 32'(ld_ready), 32'd1);
        chk(fn_done == 1'b0, "R6 not done", 32'(fn_done), 32'd0);
        mem_ready = 1'b1;
        wait_done();
        chk(sb_empty == 1'b1, "R6 done when empty", 32'(sb_empty), 32'd1);
        @(negedge clk); #1;
        chk(st_stall == 1'b0, "R6 released", 32'(st_stall), 32'd0);

        // R7 load fence
        rc = resp_cnt;
        load_issue(32'h38);
        fence_req(2'b01);
        chk(ld_ready == 1'b0, "R7 loads blocked", 32'(ld_ready), 32'd0);
        wait_done();
        @(negedge clk); #1;
        chk(resp_cnt == rc + 1, "R7 earlier load answered", 32'(resp_cnt), 32'(rc + 1));
        chk(last_resp == 32'hA000_000E, "R7 load data", last_resp, 32'hA000_000E);
        chk(ld_ready == 1'b1, "R7 released", 32'(ld_ready), 32'd1);

        // R8 full fence
        mem_ready = 1'b0;
        do_store(32'h3C, 32'h9999);
        fence_req(2'b10);
        chk(st_stall == 1'b1 && ld_ready == 1'b0, "R8 both blocked",
            {30'd0, st_stall, ld_ready}, 32'd2);
        mem_ready = 1'b1;
        wait_done();
        chk(sb_empty == 1'b1, "R8 done when empty", 32'(sb_empty), 32'd1);
        load_issue(32'h3C);
        load_wait(d, f);
        chk(d == 32'h9999 && f == 1'b0, "R8 drained value", d, 32'h9999);

        // R9 lock
        mem_ready = 1'b0;
        do_store(32'h00, 32'h1234);
        fence_req(2'b11);
        chk(st_stall == 1'b1 && ld_ready == 1'b0, "R9 both blocked",
            {30'd0, st_stall, ld_ready}, 32'd2);
        repeat (3) @(negedge clk);
        #1;
        chk(fn_done == 1'b0, "R9 waits for drain", 32'(fn_done), 32'd0);
        mem_ready = 1'b1;
        wait_done();
        chk(sb_empty == 1'b1, "R9 drained at done", 32'(sb_empty), 32'd1);

        chk(bad_rd == 0, "R5 no read while buffered", 32'(bad_rd), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule